// File: doc/BRIEF.md
# Decade Up/Down Counter with Programmable Divide Mode

This block is a synchronous counter that steps through the decimal digits 0 to 9 on a four-bit BCD output. The direction is chosen by one input. An active-low enable lets the count advance or hold. An active-low synchronous load copies a four-bit preset into the counter at any point in the sequence. The counter has no clear input. It is cleared by loading a preset of zero.

In divide mode the counter always counts down, whatever the direction input says. A built-in terminal detector reloads the preset once the count reaches one. The terminal pulse output is therefore high for one cycle in every N enabled cycles, where N is the preset. The block then works as a programmable divide-by-N clock divider.

The next count is chosen each cycle by a per-cycle transition selector. It picks one of five named transitions:
- **ST_LOAD**: external load.
- **ST_HOLD**: enable inactive.
- **ST_UP**: increment with wrap.
- **ST_DOWN**: decrement with wrap.
- **ST_RELOAD**: terminal reload in divide mode.

The state is the count register itself.

Top module: `bcd_divctr`

## Requirements
- R1: While `rst_n` is low, the count is 0. After reset is released it stays 0 until the first active transition.
- R2: With `load_n` high, `cnt_en_n` low, `divide_mode` low and `count_down` low, each clock increments the count. From 9, or from any value 10 to 15, the next count is 0.
- R3: With `load_n` high, `cnt_en_n` low and counting down (`count_down` high, divide mode off), each clock decrements the count. From 0 the next count is 9. Values 10 to 15 decrement normally, so 13 goes to 12.
- R4: When `load_n` is low at a clock edge, the count becomes `preset_val` after that edge. This holds regardless of the enable, the direction or the mode. Values 10 to 15 are loaded unchanged.
- R5: When `load_n` is high and `cnt_en_n` is high, the count holds. This also applies in divide mode, where no reload takes place.
- R6: `edge_flag` is high exactly when the effective direction is up and the count is 9, or the effective direction is down and the count is 0. Divide mode forces the effective direction to down.
- R7: In divide mode, `count_down` is ignored. `reload_pulse` is high exactly when the count is 0 or 1. On an enabled clock in that condition, the next count is `preset_val`; otherwise the count decrements. For preset N ≥ 1 this gives one pulse per N enabled clocks.
- R8: In divide mode with a preset of 0, the count stays at 0 and `reload_pulse` stays high on every cycle.
- R9: Loading a preset of 0 clears the counter from any value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, count to 0 |
| cnt_en_n | input | 1 | Active-low count enable |
| count_down | input | 1 | 1 = count down, 0 = count up (ignored in divide mode) |
| load_n | input | 1 | Active-low synchronous parallel load |
| preset_val | input | 4 | Value copied in on load or terminal reload |
| divide_mode | input | 1 | 1 = programmable divide-by-N mode |
| count_q | output | 4 | Current BCD count |
| edge_flag | output | 1 | Maximum/minimum flag for the effective direction |
| reload_pulse | output | 1 | Terminal detect in divide mode (one pulse per N cycles) |

## Verification
Every change of `count_q` is due one rising edge after the inputs that cause it. The inputs are applied at a falling edge, so the result appears at the following rising edge. `edge_flag` and `reload_pulse` are combinational from the count and the mode inputs, so they are valid in the same cycle as the count they describe. The bench drives inputs at a falling edge and lets one rising edge pass. It then compares all three outputs at the next falling edge against a behavioural model that it advanced at that same rising edge. The divide-by-N rate is checked separately by counting the pulses over a whole number of periods.

// File: rtl/bcd_divctr_pkg.sv
package bcd_divctr_pkg;
    typedef enum logic [2:0] {
        ST_HOLD,
        ST_LOAD,
        ST_UP,
        ST_DOWN,
        ST_RELOAD
    } ctr_step_e;
endpackage

// File: rtl/ctr_step_select.sv
module ctr_step_select
    import bcd_divctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             load_n,
    input  logic             cnt_en_n,
    input  logic             count_down,
    input  logic             divide_mode,
    input  logic [WIDTH-1:0] cur,
    output ctr_step_e        step,
    output logic             term_hit
);
    localparam logic [WIDTH-1:0] ONE_V = WIDTH'(1);

    always_comb begin
        term_hit = divide_mode && (cur <= ONE_V);
        if (!load_n)
            step = ST_LOAD;
        else if (cnt_en_n)
            step = ST_HOLD;
        else if (divide_mode)
            step = term_hit ? ST_RELOAD : ST_DOWN;
        else if (count_down)
            step = ST_DOWN;
        else
            step = ST_UP;
    end
endmodule

// File: rtl/ctr_next_value.sv
module ctr_next_value
    import bcd_divctr_pkg::*;
#(
    parameter int WIDTH      = 4,
    parameter int LAST_DIGIT = 9
) (
    input  ctr_step_e        step,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST_DIGIT);
    localparam logic [WIDTH-1:0] ONE_V  = WIDTH'(1);

    always_comb begin
        unique case (step)
            ST_HOLD:   nxt = cur;
            ST_LOAD:   nxt = preset;
            ST_RELOAD: nxt = preset;
            ST_UP:     nxt = (cur >= LAST_V) ? '0 : cur + ONE_V;
            ST_DOWN:   nxt = (cur == '0) ? LAST_V : cur - ONE_V;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/bcd_divctr.sv
module bcd_divctr
    import bcd_divctr_pkg::*;
#(
    parameter int WIDTH      = 4,
    parameter int LAST_DIGIT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en_n,
    input  logic             count_down,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset_val,
    input  logic             divide_mode,
    output logic [WIDTH-1:0] count_q,
    output logic             edge_flag,
    output logic             reload_pulse
);
    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST_DIGIT);

    ctr_step_e        step;
    logic             term_hit;
    logic [WIDTH-1:0] count_nxt;

    ctr_step_select #(.WIDTH(WIDTH)) u_sel (
        .load_n      (load_n),
        .cnt_en_n    (cnt_en_n),
        .count_down  (count_down),
        .divide_mode (divide_mode),
        .cur         (count_q),
        .step        (step),
        .term_hit    (term_hit)
    );

    ctr_next_value #(.WIDTH(WIDTH), .LAST_DIGIT(LAST_DIGIT)) u_nxt (
        .step   (step),
        .cur    (count_q),
        .preset (preset_val),
        .nxt    (count_nxt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else
            count_q <= count_nxt;
    end

    // outputs
    always_comb begin
        if (divide_mode || count_down)
            edge_flag = (count_q == '0);
        else
            edge_flag = (count_q == LAST_V);
        reload_pulse = term_hit;
    end
endmodule

// File: rtl/bcd_divctr_chk.sv
module bcd_divctr_chk #(
    parameter int WIDTH      = 4,
    parameter int LAST_DIGIT = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en_n,
    input logic             count_down,
    input logic             load_n,
    input logic [WIDTH-1:0] preset_val,
    input logic             divide_mode,
    input logic [WIDTH-1:0] count_q,
    input logic             edge_flag,
    input logic             reload_pulse
);
    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST_DIGIT);
    localparam logic [WIDTH-1:0] ONE_V  = WIDTH'(1);

    always_comb begin
        if (!rst_n) assert_reset_zero_R1: assert (count_q == '0);
    end

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> count_q == $past(preset_val));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en_n) |=> $stable(count_q));

    assert_up_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !divide_mode && !count_down && count_q >= LAST_V)
        |=> count_q == '0);

    assert_down_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !divide_mode && count_down && count_q == '0)
        |=> count_q == LAST_V);

    assert_flag_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_flag |-> (count_q == '0 || count_q == LAST_V));

    assert_pulse_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reload_pulse |-> (divide_mode && count_q <= ONE_V));

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && divide_mode && count_q <= ONE_V)
        |=> count_q == $past(preset_val));
endmodule

bind bcd_divctr bcd_divctr_chk #(.WIDTH(WIDTH), .LAST_DIGIT(LAST_DIGIT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_en_n     (cnt_en_n),
    .count_down   (count_down),
    .load_n       (load_n),
    .preset_val   (preset_val),
    .divide_mode  (divide_mode),
    .count_q      (count_q),
    .edge_flag    (edge_flag),
    .reload_pulse (reload_pulse)
);

// File: tb/sim_bcd_divctr.sv
`timescale 1ns/1ps
module sim_bcd_divctr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en_n = 1'b1;
    logic       count_down = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] preset_val = 4'd0;
    logic       divide_mode = 1'b0;
    logic [3:0] count_q;
    logic       edge_flag;
    logic       reload_pulse;

    int checks = 0;
    int errors = 0;
    int model = 0;
    int pulses = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bcd_divctr u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .count_down(count_down),
        .load_n(load_n), .preset_val(preset_val), .divide_mode(divide_mode),
        .count_q(count_q), .edge_flag(edge_flag), .reload_pulse(reload_pulse)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        bit down_eff;
        int exp_flag;
        int exp_pulse;
        down_eff  = divide_mode || count_down;
        exp_flag  = down_eff ? (model == 0) : (model == 9);
        exp_pulse = divide_mode && (model <= 1);
        check(tag, int'(count_q), model, "count");
        check("R6", int'(edge_flag), exp_flag, "edge_flag");
        check("R7", int'(reload_pulse), exp_pulse, "reload_pulse");
        if (reload_pulse) pulses++;
    endtask

    // one clock: inputs already driven; advance model at posedge, compare at negedge
    task automatic step(input string tag);
        @(posedge clk);
        if (!load_n) model = int'(preset_val);
        else if (!cnt_en_n) begin
            if (divide_mode) model = (model <= 1) ? int'(preset_val) : model - 1;
            else if (count_down) model = (model == 0) ? 9 : model - 1;
            else model = (model >= 9) ? 0 : model + 1;
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic load(input int v, input string tag);
        load_n = 1'b0; preset_val = 4'(v);
        step(tag);
        load_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        step("R1");

        // up counting with wrap
        load(7, "R4");
        cnt_en_n = 1'b0;
        for (int i = 0; i < 5; i++) step("R2");
        // out of range loads
        load(12, "R4");
        step("R2");
        count_down = 1'b1;
        load(13, "R4");
        step("R3");
        step("R3");
        // clear by loading zero
        load(0, "R9");
        for (int i = 0; i < 4; i++) step("R3");
        // hold, and load while disabled
        cnt_en_n = 1'b1;
        for (int i = 0; i < 3; i++) step("R5");
        load(4, "R4");
        step("R5");
        load(0, "R9");

        // divide mode, preset 6, direction input set to up to show it is ignored
        count_down = 1'b0; divide_mode = 1'b1; cnt_en_n = 1'b0;
        load(6, "R7");
        pulses = 0;
        for (int i = 0; i < 30; i++) step("R7");
        check("R7", pulses, 30 / 6, "pulses in 30 clocks");
        // hold in divide mode: no reload even at terminal
        load(1, "R4");
        cnt_en_n = 1'b1;
        for (int i = 0; i < 3; i++) step("R5");
        cnt_en_n = 1'b0;
        // preset 3 with count_down high
        count_down = 1'b1;
        load(3, "R7");
        pulses = 0;
        for (int i = 0; i < 12; i++) step("R7");
        check("R7", pulses, 12 / 3, "pulses in 12 clocks");
        // out-of-range preset in divide mode
        load(11, "R7");
        pulses = 0;
        for (int i = 0; i < 22; i++) step("R7");
        check("R7", pulses, 2, "pulses in 22 clocks preset 11");
        // preset zero holds at zero with pulse high
        load(0, "R8");
        pulses = 0;
        for (int i = 0; i < 8; i++) step("R8");
        check("R8", pulses, 8, "pulse high every cycle");
        check("R8", int'(count_q), 0, "count stays zero");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule